// File: doc/BRIEF.md
# PIO Strobe Timing Count Calculator

This block turns nanosecond timing figures for a programmed-I/O transfer mode into the clock counts and encoded register bytes that a drive strobe sequencer consumes. The caller presents the requested mode number, the setup, active and full cycle times for that mode, the bus clock period, the controller revision, the drive slot and the counts already held by the other drive on the same channel. It then pulses `start`. One shared divider forms every ceiling division in turn. When the results are ready, the block raises `done` for one cycle.

The block applies the hardware's count limits. Recovery clocks above the maximum are moved into the active count. Newer revisions receive an offset on the recovery count. The two drives of the secondary channel share a single timing register, so slots 2 and 3 take the slower of their own and their neighbour's value in each field before encoding. The outputs hold the drive's own counts, which the caller stores for later merges, and two packed bytes ready to be written: an address-setup byte and an active/recovery byte.

Top module: `pio_clk_conv`

## Requirements
- R1: `mode_eff` reports the requested mode, with any value above 5 replaced by 5.
- R2: `setup_cnt` equals the setup time divided by the clock period, rounded up.
- R3: `recov_cnt` starts from the larger of two values. The first is the cycle time minus the setup and active times, divided by the period and rounded up, or 0 when that difference is not positive. The second is the cycle count rounded up, minus the setup and active counts, or 0 when that would be negative. The chosen value is then raised to at least 2.
- R4: The active count is the active time divided by the period and rounded up, then raised to at least 2.
- R5: A recovery count above 17 adds its excess to the active count and is set to 17. The active count is then limited to 16, and `active_cnt` shows the result.
- R6: When `chip_rev` is greater than 1, one is subtracted from the recovery count. Whatever the revision, the recovery count is then limited to 16.
- R7: For `drive_idx` 2 or 3 with `mate_present` high, each encoded field uses the larger of the drive's count and the matching mate count. Slots 0 and 1 ignore the mate inputs. `setup_cnt`, `active_cnt` and `recov_cnt` always show the drive's own counts, before any merge.
- R8: `addr_byte[7:6]` encodes the setup count: 4 gives 00, 3 gives 10, 1 or 2 gives 01, and any other value gives 11. `addr_byte[5:0]` is zero.
- R9: `timing_byte[7:4]` holds the low four bits of the active count and `timing_byte[3:0]` the low four bits of the recovery count, so a count of 16 appears as 0.
- R10: A `start` with `clk_ns` equal to 0 gives `done` and `err` together in the following cycle and leaves every result output unchanged.
- R11: `done` lasts exactly one cycle, and all result outputs are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion (taken while idle) |
| pio_mode | input | 3 | Requested transfer mode |
| setup_ns | input | TW | Address setup time in ns |
| active_ns | input | TW | Strobe active time in ns |
| cycle_ns | input | TW | Full cycle time in ns |
| clk_ns | input | CKW | Bus clock period in ns |
| chip_rev | input | 2 | Controller revision |
| drive_idx | input | 2 | Drive slot 0 to 3 |
| mate_present | input | 1 | Other drive on the channel exists |
| mate_setup | input | TW | Mate's setup count |
| mate_active | input | 5 | Mate's active count |
| mate_recov | input | 5 | Mate's recovery count |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Zero clock period rejected |
| mode_eff | output | 3 | Clamped mode |
| setup_cnt | output | TW | Drive's own setup count |
| active_cnt | output | 5 | Drive's own active count |
| recov_cnt | output | 5 | Drive's own recovery count |
| addr_byte | output | 8 | Encoded setup byte |
| timing_byte | output | 8 | Packed active/recovery byte |

## Verification
A divider step that goes wrong, or a quotient stored in the wrong slot, appears as a wrong count in the very pulse where `done` rises. The rounding behaviour is therefore compared on every conversion, across periods that leave remainders and periods that divide evenly. A limit applied out of order changes the spill-over result, and this shows only when the recovery count exceeds 17. Short clock periods are used to reach that case. Merge faults alter the packed bytes while the own-count outputs stay correct, so both views are compared, and slot and mate values are chosen at random.

// File: rtl/pio_clk_conv_pkg.sv
package pio_clk_conv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_FIN} conv_state_t;

  // Two-bit address-setup code in the position the timing register decodes
  function automatic logic [1:0] setup_code(input logic [15:0] cnt);
    case (cnt)
      16'd4:         setup_code = 2'b00;
      16'd3:         setup_code = 2'b10;
      16'd1, 16'd2:  setup_code = 2'b01;
      default:       setup_code = 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/pio_div_seq.sv
module pio_div_seq #(
  parameter int NW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          fin,
  output logic [NW-1:0] ceil_q
);
  localparam int CNTW = $clog2(NW + 1);

  logic [DW:0]     rem;
  logic [NW-1:0]   quo;
  logic [CNTW-1:0] cnt;
  logic            run;
  logic [DW:0]     sh;
  logic            ge;

  assign sh = {rem[DW-1:0], quo[NW-1]};
  assign ge = (sh >= {1'b0, den});

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
      quo <= '0;
      cnt <= '0;
      run <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rem <= '0;
        quo <= num;
        cnt <= CNTW'(NW);
        run <= 1'b1;
      end else if (run) begin
        rem <= ge ? (sh - {1'b0, den}) : sh;
        quo <= {quo[NW-2:0], ge};
        cnt <= cnt - 1'b1;
        if (cnt == CNTW'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  // Round up on any remainder; the quotient is below the numerator in that case
  assign ceil_q = quo + {{(NW-1){1'b0}}, |rem};
endmodule

// File: rtl/pio_count_limit.sv
module pio_count_limit
  import pio_clk_conv_pkg::*;
#(
  parameter int TW = 10
) (
  input  logic [TW-1:0] cs,
  input  logic [TW-1:0] ca,
  input  logic [TW-1:0] cr,
  input  logic [TW-1:0] cc,
  input  logic [1:0]    rev,
  input  logic [1:0]    idx,
  input  logic          mate_present,
  input  logic [TW-1:0] mate_setup,
  input  logic [4:0]    mate_active,
  input  logic [4:0]    mate_recov,
  output logic [TW-1:0] own_setup,
  output logic [4:0]    own_act,
  output logic [4:0]    own_rec,
  output logic [7:0]    addr_byte,
  output logic [7:0]    timing_byte
);
  localparam int XW = TW + 2;

  logic [XW-1:0] sa, r2, rec, act;
  logic [TW-1:0] m_set;
  logic [4:0]    m_act, m_rec;
  logic          use_mate;

  always_comb begin
    sa  = XW'(cs) + XW'(ca);
    r2  = (XW'(cc) > sa) ? (XW'(cc) - sa) : '0;
    rec = (XW'(cr) > r2) ? XW'(cr) : r2;
    if (rec < XW'(2)) rec = XW'(2);
    act = (ca < TW'(2)) ? XW'(2) : XW'(ca);
    if (rec > XW'(17)) begin
      act = act + rec - XW'(17);
      rec = XW'(17);
    end
    if (act > XW'(16)) act = XW'(16);
    if (rev > 2'd1) rec = rec - 1'b1;
    if (rec > XW'(16)) rec = XW'(16);
  end

  assign own_setup = cs;
  assign own_act   = act[4:0];
  assign own_rec   = rec[4:0];

  assign use_mate = idx[1] & mate_present;
  assign m_set = (use_mate && mate_setup > cs)      ? mate_setup  : cs;
  assign m_act = (use_mate && mate_active > own_act) ? mate_active : own_act;
  assign m_rec = (use_mate && mate_recov > own_rec)  ? mate_recov  : own_rec;

  assign addr_byte   = {setup_code(16'(m_set)), 6'b0};
  assign timing_byte = {m_act[3:0], m_rec[3:0]};
endmodule

// File: rtl/pio_clk_conv.sv
module pio_clk_conv
  import pio_clk_conv_pkg::*;
#(
  parameter int TW  = 10,
  parameter int CKW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2:0]     pio_mode,
  input  logic [TW-1:0]  setup_ns,
  input  logic [TW-1:0]  active_ns,
  input  logic [TW-1:0]  cycle_ns,
  input  logic [CKW-1:0] clk_ns,
  input  logic [1:0]     chip_rev,
  input  logic [1:0]     drive_idx,
  input  logic           mate_present,
  input  logic [TW-1:0]  mate_setup,
  input  logic [4:0]     mate_active,
  input  logic [4:0]     mate_recov,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [2:0]     mode_eff,
  output logic [TW-1:0]  setup_cnt,
  output logic [4:0]     active_cnt,
  output logic [4:0]     recov_cnt,
  output logic [7:0]     addr_byte,
  output logic [7:0]     timing_byte
);
  localparam int NQ = 4;

  conv_state_t    state;
  logic [1:0]     sel;
  logic           div_go, div_fin;
  logic [TW-1:0]  div_num, div_q;
  logic [TW-1:0]  q [NQ];
  logic [TW:0]    sa_ns;
  logic [TW-1:0]  rec_ns;

  logic [2:0]     l_mode;
  logic [TW-1:0]  l_set, l_act, l_cyc, l_mset;
  logic [CKW-1:0] l_clk;
  logic [1:0]     l_rev, l_idx;
  logic           l_mp;
  logic [4:0]     l_mact, l_mrec;

  logic [TW-1:0]  n_set;
  logic [4:0]     n_act, n_rec;
  logic [7:0]     n_ab, n_tb;

  assign sa_ns  = {1'b0, l_set} + {1'b0, l_act};
  assign rec_ns = ({1'b0, l_cyc} > sa_ns) ? TW'({1'b0, l_cyc} - sa_ns) : '0;

  always_comb begin
    case (sel)
      2'd0:    div_num = l_set;
      2'd1:    div_num = l_act;
      2'd2:    div_num = rec_ns;
      default: div_num = l_cyc;
    endcase
  end

  pio_div_seq #(.NW(TW), .DW(CKW)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .num(div_num), .den(l_clk),
    .fin(div_fin), .ceil_q(div_q)
  );

  pio_count_limit #(.TW(TW)) u_lim (
    .cs(q[0]), .ca(q[1]), .cr(q[2]), .cc(q[3]),
    .rev(l_rev), .idx(l_idx), .mate_present(l_mp),
    .mate_setup(l_mset), .mate_active(l_mact), .mate_recov(l_mrec),
    .own_setup(n_set), .own_act(n_act), .own_rec(n_rec),
    .addr_byte(n_ab), .timing_byte(n_tb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      sel         <= '0;
      div_go      <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
      mode_eff    <= '0;
      setup_cnt   <= '0;
      active_cnt  <= '0;
      recov_cnt   <= '0;
      addr_byte   <= '0;
      timing_byte <= '0;
      l_mode <= '0; l_set <= '0; l_act <= '0; l_cyc <= '0; l_clk <= '0;
      l_rev  <= '0; l_idx <= '0; l_mp  <= 1'b0; l_mset <= '0;
      l_mact <= '0; l_mrec <= '0;
      for (int i = 0; i < NQ; i++) q[i] <= '0;
    end else begin
      done   <= 1'b0;
      err    <= 1'b0;
      div_go <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          l_mode <= pio_mode;  l_set <= setup_ns; l_act <= active_ns;
          l_cyc  <= cycle_ns;  l_clk <= clk_ns;   l_rev <= chip_rev;
          l_idx  <= drive_idx; l_mp  <= mate_present;
          l_mset <= mate_setup; l_mact <= mate_active; l_mrec <= mate_recov;
          if (clk_ns == '0) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            sel    <= '0;
            div_go <= 1'b1;
            state  <= ST_DIV;
          end
        end
        ST_DIV: if (div_fin) begin
          q[sel] <= div_q;
          if (sel == 2'(NQ - 1)) begin
            state <= ST_FIN;
          end else begin
            sel    <= sel + 1'b1;
            div_go <= 1'b1;
          end
        end
        default: begin
          mode_eff    <= (l_mode > 3'd5) ? 3'd5 : l_mode;
          setup_cnt   <= n_set;
          active_cnt  <= n_act;
          recov_cnt   <= n_rec;
          addr_byte   <= n_ab;
          timing_byte <= n_tb;
          done        <= 1'b1;
          state       <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/pio_clk_conv_chk.sv
module pio_clk_conv_chk #(
  parameter int TW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic          err,
  input logic          busy,
  input logic [2:0]    mode_eff,
  input logic [4:0]    active_cnt,
  input logic [4:0]    recov_cnt,
  input logic [7:0]    addr_byte,
  input logic [7:0]    timing_byte,
  input logic [TW-1:0] setup_cnt
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R11
  AST_MODE_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (mode_eff <= 3'd5)); // R1
  AST_ACTIVE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (active_cnt >= 5'd2 && active_cnt <= 5'd16)); // R5
  AST_RECOV_RANGE: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (recov_cnt >= 5'd1 && recov_cnt <= 5'd16)); // R6
  AST_ZERO_PERIOD_HOLD: assert property (@(posedge clk) disable iff (rst)
    err |-> ($stable(addr_byte) && $stable(timing_byte) && $stable(setup_cnt))); // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    err |-> done); // R10
  AST_ADDR_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    done |-> (addr_byte[5:0] == 6'd0)); // R8
endmodule

bind pio_clk_conv pio_clk_conv_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst(rst), .done(done), .err(err), .busy(busy),
  .mode_eff(mode_eff), .active_cnt(active_cnt), .recov_cnt(recov_cnt),
  .addr_byte(addr_byte), .timing_byte(timing_byte), .setup_cnt(setup_cnt)
);

// File: tb/pio_clk_conv_tb.sv
module pio_clk_conv_tb;
  localparam int TW  = 10;
  localparam int CKW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] pio_mode = '0;
  logic [TW-1:0] setup_ns = '0, active_ns = '0, cycle_ns = '0, mate_setup = '0;
  logic [CKW-1:0] clk_ns = '0;
  logic [1:0] chip_rev = '0, drive_idx = '0;
  logic mate_present = 1'b0;
  logic [4:0] mate_active = '0, mate_recov = '0;
  logic busy, done, err;
  logic [2:0] mode_eff;
  logic [TW-1:0] setup_cnt;
  logic [4:0] active_cnt, recov_cnt;
  logic [7:0] addr_byte, timing_byte;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  pio_clk_conv #(.TW(TW), .CKW(CKW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .pio_mode(pio_mode),
    .setup_ns(setup_ns), .active_ns(active_ns), .cycle_ns(cycle_ns),
    .clk_ns(clk_ns), .chip_rev(chip_rev), .drive_idx(drive_idx),
    .mate_present(mate_present), .mate_setup(mate_setup),
    .mate_active(mate_active), .mate_recov(mate_recov),
    .busy(busy), .done(done), .err(err), .mode_eff(mode_eff),
    .setup_cnt(setup_cnt), .active_cnt(active_cnt), .recov_cnt(recov_cnt),
    .addr_byte(addr_byte), .timing_byte(timing_byte)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int cdiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction

  function automatic int t_set(input int m);
    case (m) 0: return 70; 1: return 50; 2: return 30; 3: return 30; 4: return 25; default: return 20; endcase
  endfunction
  function automatic int t_act(input int m);
    case (m) 0: return 165; 1: return 125; 2: return 100; 3: return 80; 4: return 70; default: return 50; endcase
  endfunction
  function automatic int t_cyc(input int m);
    case (m) 0: return 600; 1: return 383; 2: return 240; 3: return 180; 4: return 120; default: return 100; endcase
  endfunction

  task automatic model(input int S, input int A, input int CY, input int C,
                       input int rev, input int idx, input int mp,
                       input int ms, input int ma, input int mr,
                       output int e_s, output int e_a, output int e_r,
                       output int e_ab, output int e_tb);
    int s, a, r, rc, cc, r2, code, xs, xa, xr;
    s  = cdiv(S, C);
    a  = cdiv(A, C);
    rc = (CY - S - A > 0) ? cdiv(CY - S - A, C) : 0;
    cc = cdiv(CY, C);
    r2 = (cc > s + a) ? cc - s - a : 0;
    r  = (rc > r2) ? rc : r2;
    if (r < 2) r = 2;
    if (a < 2) a = 2;
    if (r > 17) begin a = a + r - 17; r = 17; end
    if (a > 16) a = 16;
    if (rev > 1) r = r - 1;
    if (r > 16) r = 16;
    e_s = s; e_a = a; e_r = r;
    xs = s; xa = a; xr = r;
    if (idx >= 2 && mp != 0) begin
      if (ms > xs) xs = ms;
      if (ma > xa) xa = ma;
      if (mr > xr) xr = mr;
    end
    case (xs) 4: code = 0; 3: code = 2; 1, 2: code = 1; default: code = 3; endcase
    e_ab = code << 6;
    e_tb = ((xa & 15) << 4) | (xr & 15);
  endtask

  task automatic run_one(input int mode, input int S, input int A, input int CY,
                         input int C, input int rev, input int idx, input int mp,
                         input int ms, input int ma, input int mr);
    int e_s, e_a, e_r, e_ab, e_tb, wait_n;
    model(S, A, CY, C, rev, idx, mp, ms, ma, mr, e_s, e_a, e_r, e_ab, e_tb);
    @(negedge clk);
    pio_mode = 3'(mode); setup_ns = TW'(S); active_ns = TW'(A); cycle_ns = TW'(CY);
    clk_ns = CKW'(C); chip_rev = 2'(rev); drive_idx = 2'(idx); mate_present = mp[0];
    mate_setup = TW'(ms); mate_active = 5'(ma); mate_recov = 5'(mr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_n = 0;
    while (!done && wait_n < 200) begin @(negedge clk); wait_n++; end
    chk("R11 done seen", int'(done), 1);
    chk("R1 mode", int'(mode_eff), (mode > 5) ? 5 : mode);
    chk("R2 setup count", int'(setup_cnt), e_s);
    chk("R4 R5 active count", int'(active_cnt), e_a);
    chk("R3 R6 recovery count", int'(recov_cnt), e_r);
    chk("R7 R8 setup byte", int'(addr_byte), e_ab);
    chk("R7 R9 timing byte", int'(timing_byte), e_tb);
    chk("R10 no err", int'(err), 0);
    @(negedge clk);
    chk("R11 single pulse", int'(done), 0);
  endtask

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset done", int'(done), 0);
    chk("reset busy", int'(busy), 0);
    chk("reset timing byte", int'(timing_byte), 0);

    // R1 R6 sweep: modes 0..7, several periods, both revision classes
    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 5; p++)
        for (int rv = 1; rv <= 2; rv++) begin
          int per;
          case (p) 0: per = 15; 1: per = 20; 2: per = 25; 3: per = 30; default: per = 33; endcase
          run_one(m, t_set(m > 5 ? 5 : m), t_act(m > 5 ? 5 : m), t_cyc(m > 5 ? 5 : m),
                  per, rv, 0, 0, 0, 0, 0);
        end

    // R5 spill: short period drives recovery far above 17
    run_one(0, 70, 165, 600, 5, 2, 1, 0, 0, 0, 0);
    run_one(0, 70, 165, 600, 1, 1, 0, 0, 0, 0, 0);
    // R3 minimum recovery and R4 minimum active with tiny times
    run_one(5, 1, 1, 2, 60, 1, 0, 0, 0, 0, 0);
    // R8 zero setup time gives code 11
    run_one(2, 0, 100, 240, 30, 1, 0, 0, 0, 0, 0);
    // R7 merge on slot 3 with slower mate, and slot 1 ignoring it
    run_one(4, 25, 70, 120, 30, 2, 3, 1, 5, 16, 16);
    run_one(4, 25, 70, 120, 30, 2, 1, 1, 5, 16, 16);
    run_one(4, 25, 70, 120, 30, 2, 2, 0, 5, 16, 16);

    // R10 zero period: outputs hold the previous result
    begin
      int pa, pt, ps, pc, pr;
      pa = int'(addr_byte); pt = int'(timing_byte); ps = int'(setup_cnt);
      pc = int'(active_cnt); pr = int'(recov_cnt);
      @(negedge clk);
      clk_ns = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R10 done", int'(done), 1);
      chk("R10 err", int'(err), 1);
      chk("R10 setup byte held", int'(addr_byte), pa);
      chk("R10 timing byte held", int'(timing_byte), pt);
      chk("R10 setup count held", int'(setup_cnt), ps);
      chk("R10 active held", int'(active_cnt), pc);
      chk("R10 recovery held", int'(recov_cnt), pr);
      @(negedge clk);
      chk("R11 err pulse ends", int'(done), 0);
    end

    // Random mix
    for (int k = 0; k < 300; k++)
      run_one(int'($urandom_range(0, 7)), int'($urandom_range(0, 400)),
              int'($urandom_range(0, 400)), int'($urandom_range(0, 1023)),
              int'($urandom_range(1, 255)), int'($urandom_range(0, 3)),
              int'($urandom_range(0, 3)), int'($urandom_range(0, 1)),
              int'($urandom_range(1, 6)), int'($urandom_range(2, 16)),
              int'($urandom_range(1, 16)));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule